// File: doc/BRIEF.md
# Flash Word-Program Engine

This block models the program path of a NOR-style flash array behind a word-wide bus with a byte address, write data, a write strobe and a read strobe. Software unlocks the engine with two fixed address/data writes, then writes a program opcode, and then writes the target word. That fourth write starts an internal timed programming operation on one 16-bit word. The storage is a small bank of flops that stands in for the cell array and powers up erased (all ones).

While programming runs, every read returns status flags in place of array data. Bit 7 is a data-polling bit, bit 6 toggles on each read, and bit 5 is a timeout flag. A cell can only go from 1 to 0. If a request would need any bit to go from 0 to 1, the operation never completes. After the timeout count the engine parks in an error state with the timeout flag set, and stays there until a reset command is written. Programming time and the timeout limit are parameters. So are the unlock pairs, the program opcode and the reset opcode.

Top module: `flash_prog_engine`

## Requirements
- R1: After reset, `busy` is low and a read of every word returns 16'hFFFF.
- R2: A program starts only after these three writes in order: (UNLK1_ADDR, UNLK1_DATA), then (UNLK2_ADDR, UNLK2_DATA), then (UNLK1_ADDR, PROG_OP), followed by a fourth write carrying the target address and data. A write in the second or third slot that does not match returns the decoder to idle, and nothing is programmed.
- R3: A completed program changes exactly one word, the one at byte address / 2. Its new value is the bitwise AND of the old value and the written data.
- R4: A fourth write to an odd byte address is rejected. `busy` stays low and no word changes.
- R5: When no bit of the data needs a 0 to become a 1, `busy` stays high for exactly PROG_CYCLES clock cycles after the edge that takes the fourth write.
- R6: While busy, a read at any address returns a status word:
  - bit 7 is the complement of bit 7 of the written data;
  - bit 6 is the toggle bit;
  - bit 5 is the timeout flag, and it is 0 while busy;
  - all other bits are 0.
  After completion, reads return array data again.
- R7: The toggle bit starts at 0 when a program begins. It inverts after each clock cycle in which the read strobe is high while busy, and holds otherwise.
- R8: While busy, all writes are ignored, including a complete unlock-and-program sequence.
- R9: If the data has a 1 where the stored word has a 0:
  - `busy` stays high for exactly TIMEOUT_CYCLES cycles, and then the engine enters an error state;
  - reads in the error state return bit 5 = 1, bit 7 still the complement, and bit 6 frozen from that cycle on;
  - the target word is left unchanged;
  - only a write with data RESET_OP leaves the error state, and all other writes are ignored.
- R10: Asserting `rst_n` during programming aborts it. `busy` drops and every word reads erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe, one cycle per bus read |
| rd_data | output | DATA_W | Array word, or the status word while busy or in error |
| busy | output | 1 | High while a program operation runs |

## Verification
The main function is tried with the following patterns, and each one separates a different fault:
- **Sweep over every word.** A program clears two bits that move with the word index. This separates correct word decode from aliasing, and correct AND storage from plain overwrite.
- **Second pass clearing further bits.** This checks that earlier clears persist.
- **Unlock sequences broken at each slot, and an odd target.** These tell a strict decoder from a lenient one.
- **A full sequence issued during a program.** This shows whether commands really are ignored while busy.
- **A request that sets a bit back to 1.** This separates the timeout path from normal completion through the busy length, the frozen toggle and the unchanged word.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL2,
    ST_OPC,
    ST_TGT,
    ST_BUSY,
    ST_ERR
  } fpe_state_e;

  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned TOUT_BIT = 5;
endpackage

// File: rtl/fpe_word_store.sv
module fpe_word_store #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  input  logic [IDX_W-1:0]  chk_idx,
  output logic [DATA_W-1:0] chk_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] cell_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    logic              cell_en;
    logic [DATA_W-1:0] cell_d;

    always_comb begin
      cell_en = wr_en && (wr_idx == IDX_W'(g));
      cell_d  = cell_q[g] & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[g] <= '1;
      end else if (cell_en) begin
        cell_q[g] <= cell_d;
      end
    end
  end

  assign rd_word  = cell_q[rd_idx];
  assign chk_word = cell_q[chk_idx];
endmodule

// File: rtl/fpe_prog_timer.sv
module fpe_prog_timer #(
  parameter int unsigned PROG_CYCLES    = 16,
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic will_fail,
  output logic done,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] TOUT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || run;
    cnt_d  = start ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done    = run && !will_fail && (cnt_q == PROG_LAST);
  assign expired = run &&  will_fail && (cnt_q == TOUT_LAST);
endmodule

// File: rtl/fpe_cmd_seq.sv
module fpe_cmd_seq
  import fpe_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 5,
  parameter int unsigned       DATA_W     = 16,
  parameter logic [ADDR_W-1:0] UNLK1_ADDR = 'h0A,
  parameter logic [DATA_W-1:0] UNLK1_DATA = 'h00AA,
  parameter logic [ADDR_W-1:0] UNLK2_ADDR = 'h14,
  parameter logic [DATA_W-1:0] UNLK2_DATA = 'h0055,
  parameter logic [DATA_W-1:0] PROG_OP    = 'h00A0,
  parameter logic [DATA_W-1:0] RESET_OP   = 'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              done,
  input  logic              expired,
  output fpe_state_e        state,
  output logic              start,
  output logic [ADDR_W-2:0] tgt_idx,
  output logic [DATA_W-1:0] tgt_data
);
  fpe_state_e        st_q, st_d;
  logic              ld_en;
  logic [ADDR_W-2:0] idx_q;
  logic [DATA_W-1:0] dat_q;
  logic              hit1, hit2, hit3;

  always_comb begin
    hit1  = (bus_addr == UNLK1_ADDR) && (bus_wdata == UNLK1_DATA);
    hit2  = (bus_addr == UNLK2_ADDR) && (bus_wdata == UNLK2_DATA);
    hit3  = (bus_addr == UNLK1_ADDR) && (bus_wdata == PROG_OP);
    st_d  = st_q;
    ld_en = 1'b0;
    unique case (st_q)
      ST_READ: if (bus_we && hit1) st_d = ST_UNL2;
      ST_UNL2: if (bus_we) st_d = hit2 ? ST_OPC : ST_READ;
      ST_OPC:  if (bus_we) st_d = hit3 ? ST_TGT : ST_READ;
      ST_TGT: begin
        if (bus_we) begin
          if (!bus_addr[0]) begin
            st_d  = ST_BUSY;
            ld_en = 1'b1;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_BUSY: begin
        if (expired)   st_d = ST_ERR;
        else if (done) st_d = ST_READ;
      end
      ST_ERR:  if (bus_we && (bus_wdata == RESET_OP)) st_d = ST_READ;
      default: st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_READ;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      dat_q <= '0;
    end else if (ld_en) begin
      idx_q <= bus_addr[ADDR_W-1:1];
      dat_q <= bus_wdata;
    end
  end

  assign state    = st_q;
  assign start    = ld_en;
  assign tgt_idx  = idx_q;
  assign tgt_data = dat_q;
endmodule

// File: rtl/fpe_status.sv
module fpe_status
  import fpe_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic              in_err,
  input  logic              bus_re,
  input  logic              poll_ref,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic tog_q, tog_d, tog_en;

  always_comb begin
    tog_en = start || (busy && bus_re);
    tog_d  = start ? 1'b0 : !tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  always_comb begin
    if (busy || in_err) begin
      rd_data           = '0;
      rd_data[POLL_BIT] = !poll_ref;
      rd_data[TOG_BIT]  = tog_q;
      rd_data[TOUT_BIT] = in_err;
    end else begin
      rd_data = rd_word;
    end
  end
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import fpe_pkg::*;
#(
  parameter int unsigned       ADDR_W         = 5,
  parameter int unsigned       DATA_W         = 16,
  parameter logic [ADDR_W-1:0] UNLK1_ADDR     = 'h0A,
  parameter logic [DATA_W-1:0] UNLK1_DATA     = 'h00AA,
  parameter logic [ADDR_W-1:0] UNLK2_ADDR     = 'h14,
  parameter logic [DATA_W-1:0] UNLK2_DATA     = 'h0055,
  parameter logic [DATA_W-1:0] PROG_OP        = 'h00A0,
  parameter logic [DATA_W-1:0] RESET_OP       = 'h00F0,
  parameter int unsigned       PROG_CYCLES    = 16,
  parameter int unsigned       TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  fpe_state_e        state;
  logic              start, done, expired, will_fail, in_err;
  logic [IDX_W-1:0]  tgt_idx;
  logic [DATA_W-1:0] tgt_data, rd_word, tgt_word;

  assign busy      = (state == ST_BUSY);
  assign in_err    = (state == ST_ERR);
  assign will_fail = |(tgt_data & ~tgt_word);

  fpe_cmd_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .UNLK1_ADDR(UNLK1_ADDR),
    .UNLK1_DATA(UNLK1_DATA),
    .UNLK2_ADDR(UNLK2_ADDR),
    .UNLK2_DATA(UNLK2_DATA),
    .PROG_OP   (PROG_OP),
    .RESET_OP  (RESET_OP)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .done     (done),
    .expired  (expired),
    .state    (state),
    .start    (start),
    .tgt_idx  (tgt_idx),
    .tgt_data (tgt_data)
  );

  fpe_prog_timer #(
    .PROG_CYCLES   (PROG_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .run      (busy),
    .will_fail(will_fail),
    .done     (done),
    .expired  (expired)
  );

  fpe_word_store #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (bus_addr[ADDR_W-1:1]),
    .rd_word (rd_word),
    .chk_idx (tgt_idx),
    .chk_word(tgt_word),
    .wr_en   (done),
    .wr_idx  (tgt_idx),
    .wr_data (tgt_data)
  );

  fpe_status #(
    .DATA_W(DATA_W)
  ) stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .in_err  (in_err),
    .bus_re  (bus_re),
    .poll_ref(tgt_data[POLL_BIT]),
    .rd_word (rd_word),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/flash_prog_engine_chk.sv
module flash_prog_engine_chk #(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              in_err
);
  localparam int unsigned LEN_W = $clog2(TIMEOUT_CYCLES + 2);

  logic [DATA_W-1:0] last_wd;
  logic [LEN_W-1:0]  busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wd <= '0;
    end else if (bus_we && !busy && !in_err) begin
      last_wd <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
    end else if (!busy) begin
      busy_len <= '0;
    end else if (busy_len <= LEN_W'(TIMEOUT_CYCLES)) begin
      busy_len <= busy_len + LEN_W'(1);
    end
  end

  // R6: polling bit shows the complement of the captured target data
  a_r6_poll_complement: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[7] != last_wd[7]));

  // R6: timeout flag is clear during a normal busy period
  a_r6_tout_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_data[5]);

  // R7: toggle inverts after a read strobe while busy
  a_r7_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(bus_re)) |-> (rd_data[6] != $past(rd_data[6])));

  // R7: toggle holds when no read strobe
  a_r7_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bus_re)) |-> $stable(rd_data[6]));

  // R9: error state raises the timeout flag and keeps polling stuck
  a_r9_err_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |-> (rd_data[5] && (rd_data[7] != last_wd[7])));

  // R9: toggle frozen while in the error state
  a_r9_toggle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_err && $past(in_err)) |-> $stable(rd_data[6]));

  // R9: busy never outlasts the timeout window
  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < LEN_W'(TIMEOUT_CYCLES)));

  // R8: busy and error are never both set
  a_r8_busy_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && in_err));
endmodule

bind flash_prog_engine flash_prog_engine_chk #(
  .DATA_W        (DATA_W),
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_wdata(bus_wdata),
  .rd_data  (rd_data),
  .busy     (busy),
  .in_err   (in_err)
);

// File: tb/flash_prog_engine_tb_top.sv
`timescale 1ns/1ps
module flash_prog_engine_tb_top;
  localparam int unsigned AW    = 5;
  localparam int unsigned DW    = 16;
  localparam int unsigned NW    = 1 << (AW - 1);
  localparam int unsigned PROG  = 12;
  localparam int unsigned TOUT  = 30;
  localparam logic [AW-1:0] U1A = 5'h0A;
  localparam logic [DW-1:0] U1D = 16'h00AA;
  localparam logic [AW-1:0] U2A = 5'h14;
  localparam logic [DW-1:0] U2D = 16'h0055;
  localparam logic [DW-1:0] POP = 16'h00A0;
  localparam logic [DW-1:0] ROP = 16'h00F0;

  logic          clk, rst_n, bus_we, bus_re, busy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model [NW];

  flash_prog_engine #(
    .ADDR_W(AW), .DATA_W(DW),
    .UNLK1_ADDR(U1A), .UNLK1_DATA(U1D),
    .UNLK2_ADDR(U2A), .UNLK2_DATA(U2D),
    .PROG_OP(POP), .RESET_OP(ROP),
    .PROG_CYCLES(PROG), .TIMEOUT_CYCLES(TOUT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .rd_data(rd_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic prog(input int idx, input logic [DW-1:0] d);
    wr(U1A, U1D);
    wr(U2A, U2D);
    wr(U1A, POP);
    wr(AW'(idx * 2), d);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string tag);
    logic [DW-1:0] v;
    for (int w = 0; w < NW; w++) begin
      rd(AW'(w * 2), v);
      check(tag, v, model[w]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < NW; w++) model[w] = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, s1, s2, d;
    int n;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    do_reset();

    // R1: reset state
    check("R1 busy after reset", DW'(busy), 16'h0);
    check_all("R1 erased word");

    // R6 R7: status while busy, word 0 with data 16'h00FF (bit7 = 1)
    prog(0, 16'h00FF);
    check("R5 busy after start", DW'(busy), 16'h1);
    rd(AW'(6), s1);
    rd(AW'(0), s2);
    check("R6 first status", s1, 16'h0000);
    check("R7 toggle after read", s2, 16'h0040);
    wait_idle(n);
    model[0] = 16'h00FF;
    rd(AW'(0), v);
    check("R6 true data after done", v, 16'h00FF);

    // R3 R5: sweep over all words, clearing index-dependent bits
    for (int w = 0; w < NW; w++) begin
      d = model[w] & ~((16'h0001 << w) | (16'h8000 >> w));
      prog(w, d);
      wait_idle(n);
      check("R5 busy length", DW'(n), DW'(PROG));
      model[w] = model[w] & d;
    end
    check_all("R3 after first pass");
    for (int w = 0; w < NW; w++) begin
      d = model[w] & ~(16'h00F0 << (w % 8));
      prog(w, d);
      wait_idle(n);
      model[w] = model[w] & d;
    end
    check_all("R3 after second pass");

    // R2: break the sequence at each unlock slot
    for (int k = 0; k < 3; k++) begin
      wr(U1A, (k == 0) ? 16'h1111 : U1D);
      wr(U2A, (k == 1) ? 16'h2222 : U2D);
      wr(U1A, (k == 2) ? 16'h3333 : POP);
      wr(AW'(3 * 2), 16'h0000);
      check("R2 no busy on bad sequence", DW'(busy), 16'h0);
      rd(AW'(3 * 2), v);
      check("R2 word untouched", v, model[3]);
    end

    // R4: odd target address rejected
    wr(U1A, U1D); wr(U2A, U2D); wr(U1A, POP);
    wr(AW'(4 * 2 + 1), 16'h0000);
    check("R4 no busy on odd target", DW'(busy), 16'h0);
    check_all("R4 array unchanged");

    // R8: a full sequence during busy is ignored
    d = model[2] & 16'hFF00;
    prog(2, d);
    prog(5, 16'h0000);
    wait_idle(n);
    model[2] = model[2] & d;
    check_all("R8 only first target changed");

    // R9: request setting bits back to 1 times out
    prog(0, 16'hFFFF);
    wait_idle(n);
    check("R9 busy length to timeout", DW'(n), DW'(TOUT));
    rd(AW'(0), s1);
    rd(AW'(8), s2);
    check("R9 error status", s1, 16'h0020);
    check("R9 toggle frozen", s2, 16'h0020);
    wr(AW'(0), 16'h0000);
    prog(7, 16'h0000);
    rd(AW'(0), v);
    check("R9 writes ignored in error", v, 16'h0020);
    wr(AW'(2), ROP);
    check_all("R9 array unchanged after reset command");

    // R10: reset during programming
    prog(6, 16'h0000);
    repeat (2) @(negedge clk);
    do_reset();
    check("R10 busy dropped", DW'(busy), 16'h0);
    check_all("R10 erased after abort");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule